// File: doc/BRIEF.md
# Wake Event Aggregation Controller

This block collects a parameterised number of wake inputs (96 by default, grouped into 32-bit vectors) in an always-on domain and turns them into one wake-request level. Each input first passes a two-stage sampler clocked by a slow-clock enable. A per-event polarity bit then conditions the sampled level, and a 0-to-1 transition of the conditioned level sets a sticky status bit for that event. A per-event enable mask and a per-vector routing word decide which status bits request a wake. Software reads status through the routing filter.

A second, software-owned status vector captures the same edges, but only while a latch-enable bit is held. Software samples the live input levels this way. It drives every polarity low, clears the capture vector, sets latch-enable, and then drives every polarity high: each input that is high at that moment produces an edge. Dropping latch-enable freezes the result.

All register writes cross into the slow domain through a fixed settle pipeline. A write takes effect on the fourth slow-clock tick after the cycle that issued it. Reads are answered from the applied state one system-clock cycle after the request.

Top module: `wake_aggr_ctrl`

## Requirements
- R1: After reset every polarity, mask, routing word, status bit, capture bit and latch-enable bit is 0, and `wake_req` is low. A read of any address that is not decoded (for example 0x060 or 0x1F0) returns 0.
- R2: A write issued on a system-clock cycle with `slow_tick` low becomes visible on the 4th `slow_tick` cycle after it. Until then, reads return the previous value.
- R3: The control word of event i lives at word address 0x000+i. Bit 3 is its polarity: 1 makes a rising input edge an event, and 0 makes a falling input edge an event. An input edge of the other direction leaves status unchanged.
- R4: Status of event i is sticky, and it stays set after the input returns. Bit 0 at address 0x100+i reads it. Writing 1 to bit 0 at that address clears only that event.
- R5: The mask of event i is bit 0 at address 0x080+i. Word address 0x180+v returns the masks of events 32v..32v+31 packed, with event 32v at bit 0.
- R6: Routing word v is at address 0x184+v (read/write). Address 0x188+v returns raw status of vector v ANDed with routing word v.
- R7: `wake_req` is high exactly while some event has status, mask and routing bit all set. It falls once the contributing bits are cleared or filtered out.
- R8: The capture bit of an event is set by a status-setting edge only while latch-enable (bit 0 at 0x191) is 1. When latch-enable is 0, the capture vector holds its value. Capture words are read at 0x18C+v.
- R9: Writing 1 to bit 0 at address 0x190 clears all capture bits at once.
- R10: `rd_data` is updated on the clock edge that samples `rd_en`. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock edge |
| wake_in | input | NUM_EVENTS | Raw wake inputs |
| wr_en | input | 1 | Write request |
| wr_addr | input | 9 | Word address of write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Word address of read |
| rd_data | output | 32 | Registered read data |
| wake_req | output | 1 | Aggregated wake-request level |

## Verification
The capture path is the hardest part to reach. The bench can only get there by a timed sequence of register writes, each of which lands several slow ticks late. The stimulus first parks polarities low with inputs held high or low. It then clears the capture vector, raises latch-enable, and flips the polarities high, waiting out the settle delay after every write. Next it checks that only the high inputs were recorded. Finally, with latch-enable dropped, it creates a genuine input edge to show that the frozen vector stays unchanged while hardware status still moves.

// File: rtl/wake_aggr_pkg.sv
package wake_aggr_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned POL_BIT = 3;

  localparam logic [ADDR_W-1:0] CTRL_BASE   = 9'h000;
  localparam logic [ADDR_W-1:0] MASK_BASE   = 9'h080;
  localparam logic [ADDR_W-1:0] STCLR_BASE  = 9'h100;
  localparam logic [ADDR_W-1:0] MASKPK_BASE = 9'h180;
  localparam logic [ADDR_W-1:0] ROUTE_BASE  = 9'h184;
  localparam logic [ADDR_W-1:0] REPORT_BASE = 9'h188;
  localparam logic [ADDR_W-1:0] SWST_BASE   = 9'h18C;
  localparam logic [ADDR_W-1:0] SWCLR_ADDR  = 9'h190;
  localparam logic [ADDR_W-1:0] LATCH_ADDR  = 9'h191;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_req_t;

  // Conditioned level: the input itself when polarity is 1, inverted when 0.
  function automatic logic apply_pol(logic sampled, logic pol);
    return sampled ^ ~pol;
  endfunction

  // Address of entry i within a per-event or per-vector window.
  function automatic logic [ADDR_W-1:0] slot(logic [ADDR_W-1:0] base, int unsigned i);
    return base + ADDR_W'(i);
  endfunction
endpackage

// File: rtl/wake_write_settle.sv
module wake_write_settle
  import wake_aggr_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    wr_en_i,
  input  wr_req_t wr_req_i,
  output logic    cm_valid_o,
  output wr_req_t cm_req_o
);
  logic [DEPTH-1:0] v_q;
  wr_req_t          st_q [DEPTH];

  // Stage 0 accepts the host write; on a tick it hands its content onward.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
    end else if (tick_i) begin
      v_q[0] <= wr_en_i;
    end else if (wr_en_i) begin
      v_q[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) st_q[0] <= wr_req_i;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[s] <= 1'b0;
      else if (tick_i) v_q[s] <= v_q[s-1];
    end
    always_ff @(posedge clk) begin
      if (tick_i) st_q[s] <= st_q[s-1];
    end
  end

  assign cm_valid_o = v_q[DEPTH-1] & tick_i;
  assign cm_req_o   = st_q[DEPTH-1];
endmodule

// File: rtl/wake_event_slice.sv
module wake_event_slice
  import wake_aggr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  input  logic pol_i,
  input  logic latch_i,
  input  logic clr_i,
  input  logic swclr_i,
  output logic hw_st_o,
  output logic sw_st_o
);
  logic s1_q, s2_q, prev_q, hw_q, sw_q;
  logic lvl, rise;

  assign lvl  = apply_pol(s2_q, pol_i);
  assign rise = tick_i & lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b1;
    end else if (tick_i) begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q <= 1'b0;
      sw_q <= 1'b0;
    end else begin
      if (rise) hw_q <= 1'b1;
      else if (clr_i) hw_q <= 1'b0;
      if (rise && latch_i) sw_q <= 1'b1;
      else if (swclr_i) sw_q <= 1'b0;
    end
  end

  assign hw_st_o = hw_q;
  assign sw_st_o = sw_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hw_q && !clr_i |=> hw_q); // R4
  AST_STATUS_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_q && !rise |=> !hw_q); // R3
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i && !swclr_i |=> $stable(sw_q)); // R8
  AST_CAPTURE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    swclr_i && !(rise && latch_i) |=> !sw_q); // R9
endmodule

// File: rtl/wake_read_mux.sv
module wake_read_mux
  import wake_aggr_pkg::*;
#(
  parameter int unsigned NUM_EVENTS = 96
) (
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic [NUM_EVENTS-1:0] pol_i,
  input  logic [NUM_EVENTS-1:0] mask_i,
  input  logic [NUM_EVENTS-1:0] hw_st_i,
  input  logic [NUM_EVENTS-1:0] sw_st_i,
  input  logic [NUM_EVENTS-1:0] route_i,
  input  logic                  latch_i,
  output logic [WORD_W-1:0]     word_o
);
  localparam int unsigned NUM_VEC = NUM_EVENTS / WORD_W;

  always_comb begin
    word_o = '0;
    for (int unsigned i = 0; i < NUM_EVENTS; i++) begin
      if (rd_addr_i == slot(CTRL_BASE, i))  word_o[POL_BIT] = pol_i[i];
      if (rd_addr_i == slot(MASK_BASE, i))  word_o[0] = mask_i[i];
      if (rd_addr_i == slot(STCLR_BASE, i)) word_o[0] = hw_st_i[i];
    end
    for (int unsigned v = 0; v < NUM_VEC; v++) begin
      if (rd_addr_i == slot(MASKPK_BASE, v)) word_o = mask_i[v*WORD_W +: WORD_W];
      if (rd_addr_i == slot(ROUTE_BASE, v))  word_o = route_i[v*WORD_W +: WORD_W];
      if (rd_addr_i == slot(REPORT_BASE, v))
        word_o = hw_st_i[v*WORD_W +: WORD_W] & route_i[v*WORD_W +: WORD_W];
      if (rd_addr_i == slot(SWST_BASE, v))   word_o = sw_st_i[v*WORD_W +: WORD_W];
    end
    if (rd_addr_i == LATCH_ADDR) word_o[0] = latch_i;
  end
endmodule

// File: rtl/wake_aggr_ctrl.sv
module wake_aggr_ctrl
  import wake_aggr_pkg::*;
#(
  parameter int unsigned NUM_EVENTS   = 96,
  parameter int unsigned SETTLE_TICKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slow_tick,
  input  logic [NUM_EVENTS-1:0] wake_in,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [WORD_W-1:0]     rd_data,
  output logic                  wake_req
);
  localparam int unsigned NUM_VEC = NUM_EVENTS / WORD_W;

  wr_req_t host_req, cm_req;
  logic    cm_valid;

  logic [NUM_EVENTS-1:0] pol_q, mask_q, route_q;
  logic                  latch_q;
  logic [NUM_EVENTS-1:0] clr_vec, hw_st, sw_st;
  logic                  swclr_pulse;
  logic [WORD_W-1:0]     rd_word;

  assign host_req = '{addr: wr_addr, data: wr_data};

  wake_write_settle #(.DEPTH(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .tick_i(slow_tick),
    .wr_en_i(wr_en), .wr_req_i(host_req),
    .cm_valid_o(cm_valid), .cm_req_o(cm_req)
  );

  // Write-one pulses derived from the committed write.
  always_comb begin
    for (int unsigned i = 0; i < NUM_EVENTS; i++)
      clr_vec[i] = cm_valid && cm_req.addr == slot(STCLR_BASE, i) && cm_req.data[0];
    swclr_pulse = cm_valid && cm_req.addr == SWCLR_ADDR && cm_req.data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      mask_q  <= '0;
      route_q <= '0;
      latch_q <= 1'b0;
    end else if (cm_valid) begin
      for (int unsigned i = 0; i < NUM_EVENTS; i++) begin
        if (cm_req.addr == slot(CTRL_BASE, i)) pol_q[i]  <= cm_req.data[POL_BIT];
        if (cm_req.addr == slot(MASK_BASE, i)) mask_q[i] <= cm_req.data[0];
      end
      for (int unsigned v = 0; v < NUM_VEC; v++)
        if (cm_req.addr == slot(ROUTE_BASE, v)) route_q[v*WORD_W +: WORD_W] <= cm_req.data;
      if (cm_req.addr == LATCH_ADDR) latch_q <= cm_req.data[0];
    end
  end

  for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt
    wake_event_slice u_slice (
      .clk(clk), .rst_n(rst_n), .tick_i(slow_tick),
      .pin_i(wake_in[e]), .pol_i(pol_q[e]), .latch_i(latch_q),
      .clr_i(clr_vec[e]), .swclr_i(swclr_pulse),
      .hw_st_o(hw_st[e]), .sw_st_o(sw_st[e])
    );
  end

  wake_read_mux #(.NUM_EVENTS(NUM_EVENTS)) u_rmux (
    .rd_addr_i(rd_addr), .pol_i(pol_q), .mask_i(mask_q), .hw_st_i(hw_st),
    .sw_st_i(sw_st), .route_i(route_q), .latch_i(latch_q), .word_o(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  assign wake_req = |(hw_st & mask_q & route_q);

  AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_valid |=> $stable(route_q)); // R2
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_valid |=> $stable(pol_q)); // R2
  AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |-> !wake_req); // R7
  AST_COMMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mask_q) |-> $past(slow_tick)); // R2
endmodule

// File: tb/wake_aggr_ctrl_tb_top.sv
module wake_aggr_ctrl_tb_top;
  localparam int unsigned NEV = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic [NEV-1:0] wake_in = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wake_req;

  int compared = 0;
  int mismatched = 0;
  int tick_cnt = 0;
  bit rd_pend = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  wake_aggr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wake_in(wake_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wake_req(wake_req)
  );

  // Slow-clock enable: one cycle high in every eight.
  initial forever begin
    repeat (7) @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  end

  always @(posedge clk) begin
    if (slow_tick) tick_cnt <= tick_cnt + 1;
    rd_pend <= rd_en;
  end

  // Monitor: pops the expected word for every completed read.
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (rd_data !== e) begin
        mismatched++;
        $display("FAIL %s: rd_data got %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic wait_ticks(int n);
    int t0;
    t0 = tick_cnt;
    wait (tick_cnt == t0 + n);
    @(negedge clk);
  endtask

  task automatic wr_nowait(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    wr_nowait(a, d);
    wait_ticks(5);
  endtask

  // Driver: issues the read and queues the expected result.
  task automatic rd(logic [8:0] a, logic [31:0] e, string t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_req(logic e, string t);
    @(negedge clk);
    compared++;
    if (wake_req !== e) begin
      mismatched++;
      $display("FAIL %s: wake_req got %b expected %b", t, wake_req, e);
    end
  endtask

  task automatic settle_inputs();
    wait_ticks(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and undecoded addresses
    chk_req(1'b0, "R1 reset wake_req");
    rd(9'h005, 32'h0, "R1 reset ctrl");
    rd(9'h180, 32'h0, "R1 reset mask");
    rd(9'h184, 32'h0, "R1 reset route");
    rd(9'h18C, 32'h0, "R1 reset capture");
    rd(9'h191, 32'h0, "R1 reset latch");
    rd(9'h060, 32'h0, "R1 undecoded 0x060");
    rd(9'h1F0, 32'h0, "R1 undecoded 0x1F0");

    // R2 settle delay
    wait_ticks(1);
    wr_nowait(9'h184, 32'hFFFF_FFFF);
    wait_ticks(3);
    rd(9'h184, 32'h0, "R2 before 4th tick");
    wait_ticks(1);
    rd(9'h184, 32'hFFFF_FFFF, "R2 after 4th tick");

    // R3 polarity and edge detection
    wr(9'h005, 32'h8);
    rd(9'h005, 32'h8, "R3 ctrl readback");
    wake_in[5] = 1'b1; settle_inputs();
    rd(9'h105, 32'h1, "R3 rising with pol 1");
    rd(9'h188, 32'h20, "R6 report bit5");
    wake_in[7] = 1'b1; settle_inputs();
    rd(9'h107, 32'h0, "R3 rising ignored with pol 0");
    wake_in[7] = 1'b0; settle_inputs();
    rd(9'h107, 32'h1, "R3 falling with pol 0");
    rd(9'h188, 32'hA0, "R6 report bits 5 and 7");

    // R5 / R7 mask and request
    chk_req(1'b0, "R7 no mask no request");
    wr(9'h085, 32'h1);
    chk_req(1'b1, "R7 masked-in status requests");
    rd(9'h180, 32'h20, "R5 packed mask");
    rd(9'h085, 32'h1, "R5 per-event mask");
    wr(9'h184, 32'h0);
    chk_req(1'b0, "R7 routing filters request");
    rd(9'h188, 32'h0, "R6 report filtered");
    rd(9'h105, 32'h1, "R6 raw status unfiltered");
    wr(9'h184, 32'hFFFF_FFFF);
    chk_req(1'b1, "R7 routing restored");

    // R4 sticky and per-event clear
    wake_in[5] = 1'b0; settle_inputs();
    rd(9'h105, 32'h1, "R4 sticky after input drop");
    chk_req(1'b1, "R7 level held");
    wr(9'h105, 32'h1);
    rd(9'h105, 32'h0, "R4 cleared");
    rd(9'h188, 32'h80, "R4 only event 5 cleared");
    chk_req(1'b0, "R7 falls after clear");

    // R6 on vector 2
    wr(9'h186, 32'h40);
    wr(9'h046, 32'h8);
    wr(9'h047, 32'h8);
    wr(9'h0C6, 32'h1);
    wake_in[70] = 1'b1; wake_in[71] = 1'b1; settle_inputs();
    rd(9'h146, 32'h1, "R4 event 70 status");
    rd(9'h147, 32'h1, "R4 event 71 status");
    rd(9'h18A, 32'h40, "R6 vector2 routing");
    chk_req(1'b1, "R7 vector2 request");

    // R8 capture sequence
    wr(9'h046, 32'h0);
    wr(9'h047, 32'h0);
    wr(9'h190, 32'h1);
    wr(9'h191, 32'h1);
    rd(9'h191, 32'h1, "R8 latch readback");
    wr(9'h046, 32'h8);
    wr(9'h047, 32'h8);
    wr(9'h009, 32'h8);
    wr(9'h191, 32'h0);
    rd(9'h18E, 32'hC0, "R8 high inputs captured");
    rd(9'h18C, 32'h0, "R8 low input not captured");
    wake_in[9] = 1'b1; settle_inputs();
    rd(9'h109, 32'h1, "R8 hw status still moves");
    rd(9'h18C, 32'h0, "R8 capture frozen");

    // R9 bulk clear, R10 repeatable reads
    wr(9'h190, 32'h1);
    rd(9'h18E, 32'h0, "R9 capture cleared");
    rd(9'h18A, 32'h40, "R10 first read");
    rd(9'h18A, 32'h40, "R10 repeat read");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule